// File: doc/BRIEF.md
# Clocked Byte Shift Port

This block moves single bytes over a two-wire synchronous link in half duplex. It drives its own shift clock on one wire and uses a second wire for data, which it drives while sending and listens to while receiving. A write of a byte while the port is idle starts a transmission. Clearing the receive flag while reception is enabled starts a reception. Both directions move eight bits, least significant bit first.

A speed-select input chooses the length of each bit period, either a slow or a fast number of system clocks. Within a period the shift clock is low first and high for the rest. Outgoing data changes when the clock falls and holds until the period ends. Incoming data is sampled on the rising edge. A CPU-style register port gives the write strobe and data, the read data, and two flags, each with its own clear strobe.

Top module: `sshift_port`

## Requirements
- R1: With speed select 0 a bit period lasts 12 system clocks, the shift clock low for the first 10 and high for the last 2. With speed select 1 a period lasts 4 clocks, low for 3 and high for 1. The setting is taken when a transfer starts.
- R2: A write strobe while idle loads the byte and sends its 8 bits on the data output, least significant bit first. Each bit appears when the shift clock falls and holds for the whole bit period. The data output is driven (output enable 1) only while sending.
- R3: The transmit-done flag rises exactly 8 bit periods after the clock edge that took the write, and busy falls in the same cycle. The transmit-flag clear strobe returns the flag to 0.
- R4: A write strobe while a transfer is in progress is ignored. The ongoing byte completes unchanged and no second transfer follows.
- R5: A receive-flag clear strobe while idle with receive enable at 1 starts a reception. The data input is sampled at each rising edge of the shift clock, first bit into bit 0.
- R6: The read data changes only in the cycle the receive flag is set, and it then holds the byte just received. The receive-flag clear strobe returns the flag to 0.
- R7: With receive enable at 0, the receive-flag clear strobe only clears the flag: no shift clock activity follows and the read data keeps its value.
- R8: After reset and whenever idle, the shift clock is high, the data output is 1 and not enabled, busy is 0, and both flags are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fast | input | 1 | Speed select: 0 slow period, 1 fast period |
| rx_enable | input | 1 | Allows a receive-flag clear to start a reception |
| tx_wr | input | 1 | Write strobe for the transmit byte |
| tx_wdata | input | 8 | Byte to send |
| txflag_clr | input | 1 | Clears the transmit-done flag |
| rxflag_clr | input | 1 | Clears the receive flag and may start a reception |
| rd_data | output | 8 | Last received byte |
| tx_done | output | 1 | Transmit-done flag |
| rx_full | output | 1 | Receive flag |
| busy | output | 1 | A transfer is in progress |
| sclk_o | output | 1 | Shift clock line |
| sdat_o | output | 1 | Data line output value |
| sdat_oe | output | 1 | Data line output enable |
| sdat_i | input | 1 | Data line input value |

## Verification
The checker expects the speed select to stay constant during a transfer, because it compares each low phase of the shift clock against the length that the current value of that input calls for. The bench changes the speed only between transfers, while busy is 0. It drives each received bit right after it sees the shift clock fall and holds it until the clock has risen, so every sample lands on a stable input. Strobes are single-cycle pulses applied half a cycle away from the active edge.

// File: rtl/sshift_pkg.sv
package sshift_pkg;
   typedef enum logic [1:0] {
      SS_IDLE = 2'd0,
      SS_TX   = 2'd1,
      SS_RX   = 2'd2
   } ss_state_e;
endpackage

// File: rtl/sshift_bitclk.sv
// Bit-period timer: counts system clocks inside a bit period and flags the
// rising point of the shift clock and the end of the period.
module sshift_bitclk #(
   parameter int SLOW_DIV = 12,
   parameter int SLOW_LOW = 10,
   parameter int FAST_DIV = 4,
   parameter int FAST_LOW = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   input  logic fast,
   output logic rise_evt,
   output logic end_evt
);
   localparam int MAXDIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
   localparam int CW     = $clog2(MAXDIV);

   logic [CW-1:0] cnt_q;
   logic          fast_q;
   logic [CW-1:0] div_m1;
   logic [CW-1:0] low_m1;

   generate
      if (SLOW_DIV == FAST_DIV && SLOW_LOW == FAST_LOW) begin : g_single
         assign div_m1 = CW'(SLOW_DIV - 1);
         assign low_m1 = CW'(SLOW_LOW - 1);
      end else begin : g_dual
         assign div_m1 = fast_q ? CW'(FAST_DIV - 1) : CW'(SLOW_DIV - 1);
         assign low_m1 = fast_q ? CW'(FAST_LOW - 1) : CW'(SLOW_LOW - 1);
      end
   endgenerate

   assign rise_evt = run && (cnt_q == low_m1);
   assign end_evt  = run && (cnt_q == div_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         fast_q <= 1'b0;
      end else if (restart) begin
         cnt_q  <= '0;
         fast_q <= fast;
      end else if (run) begin
         if (end_evt) cnt_q <= '0;
         else         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sshift_shreg.sv
// Shift register shared by both directions: shifts right, new bit at MSB.
module sshift_shreg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         cap_en,
   input  logic         cap_bit,
   input  logic         adv_en,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '1;
      else if (load)   q <= load_val;
      else if (cap_en) q <= {cap_bit, q[W-1:1]};
      else if (adv_en) q <= {1'b1, q[W-1:1]};
   end
endmodule

// File: rtl/sshift_port.sv
module sshift_port #(
   parameter int W        = 8,
   parameter int SLOW_DIV = 12,
   parameter int SLOW_LOW = 10,
   parameter int FAST_DIV = 4,
   parameter int FAST_LOW = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cfg_fast,
   input  logic         rx_enable,
   input  logic         tx_wr,
   input  logic [W-1:0] tx_wdata,
   input  logic         txflag_clr,
   input  logic         rxflag_clr,
   output logic [W-1:0] rd_data,
   output logic         tx_done,
   output logic         rx_full,
   output logic         busy,
   output logic         sclk_o,
   output logic         sdat_o,
   output logic         sdat_oe,
   input  logic         sdat_i
);
   import sshift_pkg::*;

   localparam int BCW = (W > 1) ? $clog2(W) : 1;
   localparam logic [BCW-1:0] LAST_BIT = BCW'(W - 1);

   generate
      if (W < 2) begin : g_bad_w
         $error("sshift_port: W must be at least 2");
      end
      if (SLOW_LOW < 1 || SLOW_LOW >= SLOW_DIV) begin : g_bad_slow
         $error("sshift_port: SLOW_LOW must lie in 1..SLOW_DIV-1");
      end
      if (FAST_LOW < 1 || FAST_LOW >= FAST_DIV) begin : g_bad_fast
         $error("sshift_port: FAST_LOW must lie in 1..FAST_DIV-1");
      end
   endgenerate

   ss_state_e      state_q;
   logic [BCW-1:0] bitn_q;
   logic           sclk_q;
   logic           txd_q;
   logic           rxf_q;
   logic [W-1:0]   rd_q;
   logic [W-1:0]   sh_q;
   logic           rise_evt;
   logic           end_evt;
   logic           idle;
   logic           start_tx;
   logic           start_rx;
   logic           last_bit;
   logic           fin_tx;
   logic           fin_rx;

   assign idle     = (state_q == SS_IDLE);
   assign start_tx = idle && tx_wr;
   assign start_rx = idle && !tx_wr && rxflag_clr && rx_enable;
   assign last_bit = (bitn_q == LAST_BIT);
   assign fin_tx   = (state_q == SS_TX) && end_evt && last_bit;
   assign fin_rx   = (state_q == SS_RX) && end_evt && last_bit;

   sshift_bitclk #(
      .SLOW_DIV(SLOW_DIV), .SLOW_LOW(SLOW_LOW),
      .FAST_DIV(FAST_DIV), .FAST_LOW(FAST_LOW)
   ) u_bitclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (start_tx || start_rx),
      .run      (!idle),
      .fast     (cfg_fast),
      .rise_evt (rise_evt),
      .end_evt  (end_evt)
   );

   sshift_shreg #(.W(W)) u_shreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start_tx),
      .load_val (tx_wdata),
      .cap_en   ((state_q == SS_RX) && rise_evt),
      .cap_bit  (sdat_i),
      .adv_en   ((state_q == SS_TX) && end_evt && !last_bit),
      .q        (sh_q)
   );

   // Transfer sequencing and shift clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SS_IDLE;
         bitn_q  <= '0;
         sclk_q  <= 1'b1;
      end else begin
         case (state_q)
            SS_IDLE: begin
               if (start_tx) begin
                  state_q <= SS_TX;
                  bitn_q  <= '0;
                  sclk_q  <= 1'b0;
               end else if (start_rx) begin
                  state_q <= SS_RX;
                  bitn_q  <= '0;
                  sclk_q  <= 1'b0;
               end
            end
            default: begin
               if (rise_evt) sclk_q <= 1'b1;
               if (end_evt) begin
                  if (last_bit) begin
                     state_q <= SS_IDLE;
                  end else begin
                     bitn_q <= bitn_q + 1'b1;
                     sclk_q <= 1'b0;
                  end
               end
            end
         endcase
      end
   end

   // Flags and read buffer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txd_q <= 1'b0;
         rxf_q <= 1'b0;
         rd_q  <= '0;
      end else begin
         if (fin_tx)          txd_q <= 1'b1;
         else if (txflag_clr) txd_q <= 1'b0;
         if (fin_rx) begin
            rxf_q <= 1'b1;
            rd_q  <= sh_q;
         end else if (rxflag_clr) begin
            rxf_q <= 1'b0;
         end
      end
   end

   assign rd_data = rd_q;
   assign tx_done = txd_q;
   assign rx_full = rxf_q;
   assign busy    = !idle;
   assign sclk_o  = sclk_q;
   assign sdat_oe = (state_q == SS_TX);
   assign sdat_o  = (state_q == SS_TX) ? sh_q[0] : 1'b1;
endmodule

// File: rtl/sshift_port_chk.sv
module sshift_port_chk #(
   parameter int W        = 8,
   parameter int SLOW_LOW = 10,
   parameter int FAST_LOW = 3
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cfg_fast,
   input logic         rx_enable,
   input logic         tx_wr,
   input logic [W-1:0] rd_data,
   input logic         tx_done,
   input logic         rx_full,
   input logic         busy,
   input logic         sclk_o,
   input logic         sdat_o,
   input logic         sdat_oe
);
   logic [7:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                low_run <= '0;
      else if (sclk_o)           low_run <= '0;
      else if (low_run != 8'hFF) low_run <= low_run + 1'b1;
   end

   // R1: low phase of each shift clock period matches the speed setting
   assert_low_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sclk_o) && busy) |-> (low_run == (cfg_fast ? 8'(FAST_LOW) : 8'(SLOW_LOW))));

   // R2: a write while idle starts a driven transfer next cycle
   assert_write_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && tx_wr) |=> (busy && sdat_oe && !sclk_o));

   // R2: data held while the shift clock stays high
   assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sdat_oe && sclk_o && $past(sclk_o) && $past(sdat_oe)) |-> $stable(sdat_o));

   // R3: transmit-done rises together with the end of the transfer
   assert_done_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_done) |-> $fell(busy));

   // R6: read data only moves when the receive flag is raised
   assert_rd_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_data) |-> $rose(rx_full));

   // R7: a reception only begins with receive enable set
   assert_rx_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && !sdat_oe) |-> $past(rx_enable));

   // R8: idle line state
   assert_idle_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sclk_o && sdat_o && !sdat_oe));
endmodule

bind sshift_port sshift_port_chk #(
   .W(W), .SLOW_LOW(SLOW_LOW), .FAST_LOW(FAST_LOW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_fast  (cfg_fast),
   .rx_enable (rx_enable),
   .tx_wr     (tx_wr),
   .rd_data   (rd_data),
   .tx_done   (tx_done),
   .rx_full   (rx_full),
   .busy      (busy),
   .sclk_o    (sclk_o),
   .sdat_o    (sdat_o),
   .sdat_oe   (sdat_oe)
);

// File: tb/sshift_port_tb.sv
module sshift_port_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_fast = 1'b0;
   logic       rx_enable = 1'b0;
   logic       tx_wr = 1'b0;
   logic [7:0] tx_wdata = 8'h00;
   logic       txflag_clr = 1'b0;
   logic       rxflag_clr = 1'b0;
   logic [7:0] rd_data;
   logic       tx_done, rx_full, busy, sclk_o, sdat_o, sdat_oe;
   logic       sdat_i = 1'b1;

   int n_chk = 0;
   int n_bad = 0;
   bit ended = 0;

   logic [7:0] exp_tx_q[$];
   logic [7:0] exp_rx_q[$];

   always #5 clk = ~clk;

   sshift_port u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_fast(cfg_fast), .rx_enable(rx_enable),
      .tx_wr(tx_wr), .tx_wdata(tx_wdata), .txflag_clr(txflag_clr),
      .rxflag_clr(rxflag_clr), .rd_data(rd_data), .tx_done(tx_done),
      .rx_full(rx_full), .busy(busy), .sclk_o(sclk_o), .sdat_o(sdat_o),
      .sdat_oe(sdat_oe), .sdat_i(sdat_i)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // Monitor: rebuilds bytes from the line and checks phase lengths
   logic       prev_sclk = 1'b1;
   logic       prev_rxf = 1'b0;
   int         low_cnt = 0;
   int         nbits = 0;
   logic [7:0] acc = 8'h00;
   bit         phase_ok = 1;
   always @(negedge clk) begin
      if (rst_n) begin
         if (sclk_o && !prev_sclk && sdat_oe) begin
            if (low_cnt != (cfg_fast ? 3 : 10)) phase_ok = 0;
            acc = {sdat_o, acc[7:1]};
            nbits++;
            if (nbits == 8) begin
               logic [7:0] e;
               e = (exp_tx_q.size() != 0) ? exp_tx_q.pop_front() : 8'hxx;
               chk(acc === e, "R2 tx byte LSB first", acc, e);
               chk(phase_ok, "R1 low phase length", low_cnt, cfg_fast ? 3 : 10);
               nbits = 0;
               phase_ok = 1;
            end
         end
         if (!sclk_o) low_cnt++;
         else         low_cnt = 0;
         if (rx_full && !prev_rxf) begin
            logic [7:0] e;
            e = (exp_rx_q.size() != 0) ? exp_rx_q.pop_front() : 8'hxx;
            chk(rd_data === e, "R5 R6 received byte", rd_data, e);
         end
         prev_sclk = sclk_o;
         prev_rxf  = rx_full;
      end
   end

   task automatic send_byte(input logic [7:0] b, input bit fast);
      int n;
      int prd;
      prd = fast ? 4 : 12;
      cfg_fast = fast;
      txflag_clr = 1'b1;
      @(negedge clk);
      txflag_clr = 1'b0;
      tx_wr = 1'b1;
      tx_wdata = b;
      exp_tx_q.push_back(b);
      @(negedge clk);
      tx_wr = 1'b0;
      n = 0;
      while (!tx_done && n < 1000) begin
         @(negedge clk);
         n++;
      end
      chk(n == 8 * prd, "R3 done after 8 periods", n, 8 * prd);
      chk(!busy, "R3 busy low at done", busy, 0);
   endtask

   task automatic recv_byte(input logic [7:0] b, input bit fast);
      int n;
      cfg_fast = fast;
      rx_enable = 1'b1;
      rxflag_clr = 1'b1;
      exp_rx_q.push_back(b);
      @(negedge clk);
      rxflag_clr = 1'b0;
      for (int i = 0; i < 8; i++) begin
         n = 0;
         while (sclk_o && n < 100) begin @(negedge clk); n++; end
         sdat_i = b[i];
         n = 0;
         while (!sclk_o && n < 100) begin @(negedge clk); n++; end
      end
      n = 0;
      while (!rx_full && n < 100) begin @(negedge clk); n++; end
      sdat_i = 1'b1;
      chk(rx_full, "R5 receive flag set", rx_full, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8: reset and idle line state
      chk(sclk_o == 1'b1, "R8 sclk idle high", sclk_o, 1);
      chk(sdat_oe == 1'b0 && sdat_o == 1'b1, "R8 data line idle", sdat_oe, 0);
      chk(!busy && !tx_done && !rx_full, "R8 flags after reset", {busy, tx_done, rx_full}, 0);

      // R1 R2 R3: both speeds, several patterns
      send_byte(8'hA5, 0);
      send_byte(8'h3C, 1);
      send_byte(8'h01, 1);
      send_byte(8'h80, 0);
      chk(sdat_oe == 1'b0, "R2 not driven after send", sdat_oe, 0);

      // R3: clear of transmit-done flag
      txflag_clr = 1'b1;
      @(negedge clk);
      txflag_clr = 1'b0;
      chk(!tx_done, "R3 flag clear", tx_done, 0);

      // R4: write while busy is ignored
      cfg_fast = 1'b1;
      tx_wr = 1'b1;
      tx_wdata = 8'h6E;
      exp_tx_q.push_back(8'h6E);
      @(negedge clk);
      tx_wr = 1'b0;
      repeat (9) @(negedge clk);
      tx_wr = 1'b1;
      tx_wdata = 8'hFF;
      @(negedge clk);
      tx_wr = 1'b0;
      while (!tx_done) @(negedge clk);
      repeat (20) @(negedge clk);
      chk(!busy && sclk_o, "R4 no second transfer", busy, 0);
      chk(exp_tx_q.size() == 0, "R4 only first byte sent", exp_tx_q.size(), 0);

      // R5 R6: reception at both speeds
      recv_byte(8'h5A, 0);
      recv_byte(8'hC3, 1);
      recv_byte(8'h00, 1);
      recv_byte(8'hE7, 0);

      // R7: clear with receive enable off only clears the flag
      rx_enable = 1'b0;
      rxflag_clr = 1'b1;
      @(negedge clk);
      rxflag_clr = 1'b0;
      chk(!rx_full, "R6 receive flag clear", rx_full, 0);
      begin
         bit quiet;
         quiet = 1;
         for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (busy || !sclk_o) quiet = 0;
         end
         chk(quiet, "R7 no reception when disabled", quiet, 1);
      end
      chk(rd_data == 8'hE7, "R7 read data kept", rd_data, 8'hE7);
      chk(exp_rx_q.size() == 0, "R5 all bytes received", exp_rx_q.size(), 0);
      finish_run();
   end
endmodule